// File: doc/BRIEF.md
# Descriptor-Based Segment Translator

This block turns a segment selector and a 16-bit offset into a 24-bit physical address for a protected segmented memory model. Each segment register holds a selector, not a base. The selector picks an entry in one of two descriptor tables, global or local. Each table has room for 8192 entries. Every entry gives a 24-bit base, a 16-bit limit and a privilege ring from 0 to 3.

When a selector is loaded, the block reads the 8-byte descriptor through a 16-bit memory read port, as four word reads. It keeps base, limit, ring and requested privilege in a shadow cache for that segment register. Later accesses through the register use only the cache. Each access is either forwarded with its physical address or refused with exactly one fault flag. The caller watches `busy` and holds its requests while a descriptor read is in progress.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `busy`, `out_valid` and all fault flags are low, and every segment register is null, so an access through any of them raises `flt_null`.
- R2: The selector carries the table index in bits 15:3, the table choice in bit 2 (0 selects the global table at `gdt_base`, 1 selects the local table at `ldt_base`) and the requested privilege in bits 1:0. The descriptor starts at the table base plus index times 8.
- R3: The descriptor is four 16-bit words at byte offsets +0, +2, +4 and +6. Word 0 is the limit. Word 1 is base bits 15:0. Word 2 bits 7:0 are base bits 23:16 and word 2 bits 9:8 are the ring. Word 3 is read and then discarded. Read data is valid one cycle after `dmem_req`.
- R4: A load of a non-null selector that is accepted while idle holds `busy` high for exactly 5 cycles. `dmem_req` is high only while `busy` is high.
- R5: While `busy` is high, access and load requests are ignored. No result or fault follows, and no segment register changes.
- R6: An accepted access gives `out_valid` one cycle later, with `out_addr` equal to base plus offset modulo 2^24.
- R7: An offset greater than the cached limit raises `flt_limit` instead of `out_valid`. An offset equal to the limit is allowed.
- R8: An access is refused with `flt_priv` when the larger of `cpl` and the selector's requested privilege is numerically greater than the descriptor ring.
- R9: A selector with index 0 and the global table is null. Loading it starts no read and leaves `busy` low. A local-table selector with index 0 is fetched like any other selector.
- R10: Each accepted access gives exactly one of `out_valid`, `flt_null`, `flt_priv` or `flt_limit`. The null fault wins over the privilege fault, which wins over the limit fault.
- R11: Each segment register keeps its own cache. Loading one register leaves the results through the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | 24 | Byte address of the global descriptor table |
| ldt_base | input | 24 | Byte address of the local descriptor table |
| cpl | input | 2 | Current privilege of the access |
| ld_valid | input | 1 | Load a selector into a segment register |
| ld_seg | input | 2 | Segment register to load |
| ld_sel | input | 16 | Selector value |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 2 | Segment register used by the access |
| acc_off | input | 16 | Offset within the segment |
| busy | output | 1 | Descriptor read in progress; requests are ignored |
| out_valid | output | 1 | Translated access issued |
| out_addr | output | 24 | Physical address of the issued access |
| flt_null | output | 1 | Access through a null selector |
| flt_priv | output | 1 | Privilege fault |
| flt_limit | output | 1 | Offset beyond the segment limit |
| dmem_req | output | 1 | Descriptor word read request |
| dmem_addr | output | 24 | Byte address of the descriptor word |
| dmem_rdata | input | 16 | Descriptor word, returned one cycle after the request |

## Verification
An access presented before a clock edge gets its result, an address or one fault, on the registered outputs after that edge. The bench drives on the falling edge and compares on the next falling edge. A load of a non-null selector raises `busy` after its edge. The bench counts the falling edges on which `busy` is high and expects five. A null load must leave `busy` low at the first falling edge. The bench's memory model answers each read one cycle after the request. Expected descriptors come from the same address hash in the bench, so every cached field is checked through later accesses, including offsets equal to the limit and one above it.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] gdt_base,
  input  logic [23:0] ldt_base,
  input  logic [1:0]  cpl,
  input  logic        ld_valid,
  input  logic [1:0]  ld_seg,
  input  logic [15:0] ld_sel,
  input  logic        acc_valid,
  input  logic [1:0]  acc_seg,
  input  logic [15:0] acc_off,
  output logic        busy,
  output logic        out_valid,
  output logic [23:0] out_addr,
  output logic        flt_null,
  output logic        flt_priv,
  output logic        flt_limit,
  output logic        dmem_req,
  output logic [23:0] dmem_addr,
  input  logic [15:0] dmem_rdata
);
  localparam int AW    = 24;
  localparam int NWORD = 4;
  localparam int CW    = $clog2(NWORD + 1);

  logic [AW-1:0] sh_base [NSEG];
  logic [15:0]   sh_lim  [NSEG];
  logic [1:0]    sh_ring [NSEG];
  logic [1:0]    sh_rpl  [NSEG];
  logic [NSEG-1:0] sh_null;

  logic          fetching;
  logic [CW-1:0] cnt;
  logic [1:0]    tgt_seg, tgt_rpl;
  logic [AW-1:0] tbl_addr;
  logic [15:0]   w0, w1;
  logic [9:0]    w2;

  logic [1:0] eff_pl;
  logic       ld_null, a_priv, a_lim;

  assign busy      = fetching;
  assign dmem_req  = fetching && (cnt < CW'(NWORD));
  assign dmem_addr = tbl_addr + AW'({cnt[1:0], 1'b0});

  assign ld_null = (ld_sel[15:2] == 14'd0);
  assign eff_pl  = (cpl > sh_rpl[acc_seg]) ? cpl : sh_rpl[acc_seg];
  assign a_priv  = eff_pl > sh_ring[acc_seg];
  assign a_lim   = acc_off > sh_lim[acc_seg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching  <= 1'b0;
      cnt       <= '0;
      tgt_seg   <= '0;
      tgt_rpl   <= '0;
      tbl_addr  <= '0;
      w0        <= '0;
      w1        <= '0;
      w2        <= '0;
      sh_null   <= '1;
      out_valid <= 1'b0;
      out_addr  <= '0;
      flt_null  <= 1'b0;
      flt_priv  <= 1'b0;
      flt_limit <= 1'b0;
      for (int i = 0; i < NSEG; i++) begin
        sh_base[i] <= '0;
        sh_lim[i]  <= '0;
        sh_ring[i] <= '0;
        sh_rpl[i]  <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      flt_null  <= 1'b0;
      flt_priv  <= 1'b0;
      flt_limit <= 1'b0;
      if (!fetching) begin
        if (acc_valid) begin
          if (sh_null[acc_seg])  flt_null  <= 1'b1;
          else if (a_priv)       flt_priv  <= 1'b1;
          else if (a_lim)        flt_limit <= 1'b1;
          else begin
            out_valid <= 1'b1;
            out_addr  <= sh_base[acc_seg] + AW'(acc_off);
          end
        end
        if (ld_valid) begin
          if (ld_null) begin
            sh_null[ld_seg] <= 1'b1;
            sh_rpl[ld_seg]  <= ld_sel[1:0];
          end else begin
            fetching <= 1'b1;
            cnt      <= '0;
            tgt_seg  <= ld_seg;
            tgt_rpl  <= ld_sel[1:0];
            tbl_addr <= (ld_sel[2] ? ldt_base : gdt_base) + AW'({ld_sel[15:3], 3'b000});
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
        case (cnt)
          CW'(1): w0 <= dmem_rdata;
          CW'(2): w1 <= dmem_rdata;
          CW'(3): w2 <= dmem_rdata[9:0];
          CW'(4): begin
            fetching         <= 1'b0;
            sh_lim[tgt_seg]  <= w0;
            sh_base[tgt_seg] <= {w2[7:0], w1};
            sh_ring[tgt_seg] <= w2[9:8];
            sh_rpl[tgt_seg]  <= tgt_rpl;
            sh_null[tgt_seg] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ld_valid,
  input logic [15:0] ld_sel,
  input logic        acc_valid,
  input logic        out_valid,
  input logic        flt_null,
  input logic        flt_priv,
  input logic        flt_limit,
  input logic        dmem_req
);
  assert_req_in_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req |-> busy);

  assert_fetch_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld_valid && ld_sel[15:2] != 14'd0) |=> busy);

  assert_null_nofetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld_valid && ld_sel[15:2] == 14'd0) |=> !busy);

  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_valid) |=> !(out_valid || flt_null || flt_priv || flt_limit));

  assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, flt_null, flt_priv, flt_limit}));

  assert_result_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || flt_null || flt_priv || flt_limit) |-> $past(acc_valid && !busy));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ld_valid(ld_valid), .ld_sel(ld_sel),
  .acc_valid(acc_valid), .out_valid(out_valid), .flt_null(flt_null),
  .flt_priv(flt_priv), .flt_limit(flt_limit), .dmem_req(dmem_req)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] gdt_base = '0, ldt_base = '0;
  logic [1:0]  cpl = '0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_seg = '0;
  logic [15:0] acc_off = '0;
  logic        busy, out_valid, flt_null, flt_priv, flt_limit, dmem_req;
  logic [23:0] out_addr, dmem_addr;
  logic [15:0] dmem_rdata = '0;

  int vectors = 0, errors = 0;

  logic [23:0] m_base [4];
  logic [15:0] m_lim  [4];
  logic [1:0]  m_ring [4], m_rpl [4];
  logic        m_null [4];

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .gdt_base(gdt_base), .ldt_base(ldt_base), .cpl(cpl),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
    .busy(busy), .out_valid(out_valid), .out_addr(out_addr),
    .flt_null(flt_null), .flt_priv(flt_priv), .flt_limit(flt_limit),
    .dmem_req(dmem_req), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] memw(logic [23:0] a);
    return (a[15:0] * 16'h9E37) ^ {a[23:16], a[7:0]} ^ 16'h5A3C;
  endfunction

  always @(posedge clk) if (dmem_req) dmem_rdata <= memw(dmem_addr);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic do_load(logic [1:0] seg, logic [15:0] sel, bit poke);
    logic [23:0] a;
    int n;
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = seg; ld_sel = sel;
    a = (sel[2] ? ldt_base : gdt_base) + {8'd0, sel[15:3], 3'b000};
    @(negedge clk);
    ld_valid = 1'b0;
    if (sel[15:2] == 14'd0) begin
      chk(busy == 1'b0, "R9 null load busy", {31'd0, busy}, 32'd0);
      m_null[seg] = 1'b1;
      m_rpl[seg]  = sel[1:0];
      return;
    end
    n = 0;
    while (busy && n < 20) begin
      if (n == 0 && poke) begin
        acc_valid = 1'b1; acc_seg = 2'($urandom); acc_off = 16'($urandom);
        ld_valid = 1'b1; ld_seg = 2'($urandom); ld_sel = 16'($urandom) | 16'h0008;
      end
      @(negedge clk);
      if (n == 0 && poke) begin
        acc_valid = 1'b0; ld_valid = 1'b0;
        chk(!(out_valid || flt_null || flt_priv || flt_limit), "R5 busy ignore",
            {28'd0, out_valid, flt_null, flt_priv, flt_limit}, 32'd0);
      end
      n++;
    end
    chk(n == 5, "R4 busy length", n, 5);
    m_lim[seg]  = memw(a);
    m_base[seg] = {memw(a + 24'd4)[7:0], memw(a + 24'd2)};
    m_ring[seg] = memw(a + 24'd4)[9:8];
    m_rpl[seg]  = sel[1:0];
    m_null[seg] = 1'b0;
  endtask

  task automatic do_acc(logic [1:0] seg, logic [15:0] off, logic [1:0] pl);
    logic [3:0] exp_f;
    logic [1:0] eff;
    string tag;
    @(negedge clk);
    acc_valid = 1'b1; acc_seg = seg; acc_off = off; cpl = pl;
    @(negedge clk);
    acc_valid = 1'b0;
    eff = (pl > m_rpl[seg]) ? pl : m_rpl[seg];
    if (m_null[seg])               begin exp_f = 4'b0100; tag = "R9 null fault"; end
    else if (eff > m_ring[seg])    begin exp_f = 4'b0010; tag = "R8 priv fault"; end
    else if (off > m_lim[seg])     begin exp_f = 4'b0001; tag = "R7 limit fault"; end
    else                           begin exp_f = 4'b1000; tag = "R6 translate"; end
    chk({out_valid, flt_null, flt_priv, flt_limit} == exp_f, {tag, " R10 result"},
        {28'd0, out_valid, flt_null, flt_priv, flt_limit}, {28'd0, exp_f});
    if (exp_f == 4'b1000)
      chk(out_addr == m_base[seg] + {8'd0, off}, "R6 R3 address",
          {8'd0, out_addr}, {8'd0, m_base[seg] + {8'd0, off}});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EC7_0A11));
    for (int i = 0; i < 4; i++) begin
      m_null[i] = 1'b1; m_base[i] = '0; m_lim[i] = '0; m_ring[i] = '0; m_rpl[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, out_valid, flt_null, flt_priv, flt_limit} == 5'd0, "R1 reset outputs",
        {27'd0, busy, out_valid, flt_null, flt_priv, flt_limit}, 32'd0);
    for (int s = 0; s < 4; s++) do_acc(2'(s), 16'h0000, 2'd0);  // R1 null after reset

    gdt_base = 24'h012340; ldt_base = 24'hFFFFF8;
    do_load(2'd1, 16'h0004, 1'b0);                              // R9 local index 0 is fetched, R2
    do_acc(2'd1, m_lim[1], 2'd0);                               // R7 boundary
    if (m_lim[1] != 16'hFFFF) do_acc(2'd1, m_lim[1] + 16'd1, 2'd0);
    do_load(2'd2, 16'h0003, 1'b0);                              // R9 global null with rpl 3
    do_acc(2'd2, 16'h0001, 2'd0);
    do_load(2'd0, 16'h0050, 1'b1);                              // R5 poke during fetch
    do_acc(2'd1, 16'h0000, 2'd3);                               // R11 seg1 unaffected, R8

    for (int it = 0; it < 300; it++) begin
      logic [15:0] sel;
      logic [1:0] sg;
      gdt_base = 24'($urandom); ldt_base = 24'($urandom);
      sel = 16'($urandom);
      if ($urandom_range(0, 7) == 0) sel = {13'd0, 1'b0, sel[1:0]};
      sg = 2'($urandom);
      do_load(sg, sel, $urandom_range(0, 3) == 0);
      for (int k = 0; k < 6; k++) begin
        logic [1:0] s2;
        logic [15:0] off;
        s2 = (k < 3) ? sg : 2'($urandom);
        case ($urandom_range(0, 4))
          0: off = m_lim[s2];
          1: off = m_lim[s2] + 16'd1;
          2: off = 16'hFFFF;
          default: off = 16'($urandom);
        endcase
        do_acc(s2, off, 2'($urandom));
      end
    end
    finish_run();
  end
endmodule